// File: doc/BRIEF.md
# GPIO Bank with Interrupt Controller

This block gives a chip a row of general-purpose pins behind a small memory-mapped register bus. Every pin has its own output-enable control, its own output drive value and a readable input level. The input level passes through a synchroniser before anything uses it. Every pin also carries an interrupt detector. Its settings cover the detection mode (level or single edge), the active polarity, an interrupt enable, a separate enable for raw status capture, and a three-bit routing code.

One registered summary interrupt leaves the block. It is high while any pin holds a latched trigger, has its interrupt enable set, and is routed to the summary with routing code 4. Host software scans the status bits and clears them by writing 1. There is no hardware detection of both edges. Software that wants both edges flips the polarity after each event.

Register offsets are per pin `n`:
- Pin configuration: `0x1000 + 0x10*n`
- Input/output: `0x1004 + 0x10*n`
- Interrupt configuration: `0x1008 + 0x10*n`
- Interrupt status: `0x100C + 0x10*n`
- Routing: `0x0400 + 0x4*n`

Only word-aligned addresses decode.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads zero except the routing field, which reads 7. The pin outputs, the output enables and the summary interrupt are low.
- R2: Bit 9 of the pin configuration register drives that pin's output enable, and bit 1 of the input/output register drives its output value. Both take effect on the clock edge that accepts the write. All other written bits read back as zero.
- R3: Bit 0 of the input/output register returns the pin level after a two-flop synchroniser. A read strobe issued one cycle after the pin changes still returns the old level, and the next read returns the new one. Writes to bit 0 are ignored.
- R4: In edge mode (interrupt configuration bit 2 = 1), polarity bit 1 = 1 selects rising edges and 0 selects falling edges. The opposite transition never triggers.
- R5: In level mode (bit 2 = 0), a pin triggers every cycle its level matches the polarity. A status clear while the level is still active is followed by re-capture on the next cycle. The summary drops for exactly one cycle.
- R6: The status bit (status register bit 0) is set by a trigger only when raw-status enable (bit 3) is 1. With bit 3 = 0 and interrupt enable (bit 0) = 1, a trigger still raises the summary while the status reads 0.
- R7: Writing 1 to status bit 0 clears both the status bit and the latched interrupt trigger. Writing 0 there has no effect.
- R8: The summary is a register holding the OR over pins of (latched trigger AND interrupt enable AND routing code == 4). It rises 4 clock edges after a pin change and falls 2 edges after the clearing write is accepted. Codes 7 and 5 block the pin.
- R9: Read data appears on the clock edge after the read strobe. Unmapped, misaligned or out-of-range pin addresses read zero.
- R10: A trigger is latched for the summary only while interrupt enable is 1. Enabling later does not raise the summary for an earlier event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after the strobe |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output drive values |
| pin_oe | output | NUM_PINS | Output enables |
| irq_summary | output | 1 | Registered summary interrupt |

## Verification
A wrong synchroniser depth or a lost edge-history flop shows as a summary interrupt that rises one edge early or late after a pin change, or as a read of the input level off by one strobe. A status or trigger latch with the wrong set/clear priority shows within two edges of a clearing write. The symptom is a summary that fails to drop, or, in level mode, fails to re-arm after a one-cycle gap. Decoder faults show on the very next read as non-zero data from an unmapped address or as configuration aliased onto a neighbouring pin.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int unsigned BUS_DW     = 32;
   localparam int unsigned CFG_OE_BIT = 9;
   localparam int unsigned IO_IN_BIT  = 0;
   localparam int unsigned IO_OUT_BIT = 1;
   localparam int unsigned STAT_BIT   = 0;
   localparam logic [2:0]  ROUTE_SUMMARY = 3'd4;
   localparam logic [2:0]  ROUTE_NONE    = 3'd7;

   typedef enum logic [2:0] {
      RK_NONE, RK_CFG, RK_IO, RK_ICFG, RK_STAT, RK_ROUTE
   } reg_kind_e;

   // bit order follows the interrupt configuration word: [3] raw, [2] edge, [1] pol, [0] enable
   typedef struct packed {
      logic raw_en;
      logic edge_mode;
      logic pol_hi;
      logic int_en;
   } icfg_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
   import gpio_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned NUM_PINS = 8,
   parameter int unsigned PIN_W    = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_kind_e         kind,
   output logic [PIN_W-1:0]  pin
);
   logic [7:0] pidx;
   logic [7:0] ridx;

   always_comb begin
      kind = RK_NONE;
      pin  = '0;
      pidx = addr[11:4];
      ridx = addr[9:2];
      if (addr[1:0] == 2'b00) begin
         if (addr[ADDR_W-1:12] == (ADDR_W-12)'(1)) begin
            if (32'(pidx) < NUM_PINS) begin
               pin = pidx[PIN_W-1:0];
               case (addr[3:2])
                  2'd0:    kind = RK_CFG;
                  2'd1:    kind = RK_IO;
                  2'd2:    kind = RK_ICFG;
                  default: kind = RK_STAT;
               endcase
            end
         end else if (addr[ADDR_W-1:10] == (ADDR_W-10)'(1)) begin
            if (32'(ridx) < NUM_PINS) begin
               pin  = ridx[PIN_W-1:0];
               kind = RK_ROUTE;
            end
         end
      end
   end
endmodule

// File: rtl/gpio_pin_unit.sv
module gpio_pin_unit
   import gpio_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_kind_e         rk,
   input  logic [BUS_DW-1:0] wdata,
   input  logic              lvl,
   output logic              oe,
   output logic              drv,
   output logic [BUS_DW-1:0] rd_word,
   output logic              stat_o,
   output logic              lat_o,
   output logic              prev_o,
   output icfg_t             icfg_o,
   output logic              contrib
);
   icfg_t      icfg_q;
   logic [2:0] route_q;
   logic       oe_q, drv_q, prev_q, stat_q, lat_q;
   logic       trig, clr;
   logic       unused_bits;

   assign unused_bits = ^{wdata[BUS_DW-1:10], wdata[8:4]};

   always_comb begin
      if (icfg_q.edge_mode)
         trig = icfg_q.pol_hi ? (lvl & ~prev_q) : (~lvl & prev_q);
      else
         trig = icfg_q.pol_hi ? lvl : ~lvl;
   end

   assign clr = wr_en && (rk == RK_STAT) && wdata[STAT_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q    <= 1'b0;
         drv_q   <= 1'b0;
         icfg_q  <= '0;
         route_q <= ROUTE_NONE;
         prev_q  <= 1'b0;
         stat_q  <= 1'b0;
         lat_q   <= 1'b0;
      end else begin
         prev_q <= lvl;
         if (wr_en) begin
            case (rk)
               RK_CFG:   oe_q    <= wdata[CFG_OE_BIT];
               RK_IO:    drv_q   <= wdata[IO_OUT_BIT];
               RK_ICFG:  icfg_q  <= icfg_t'(wdata[3:0]);
               RK_ROUTE: route_q <= wdata[2:0];
               default:  ;
            endcase
         end
         if (clr)                        stat_q <= 1'b0;
         else if (trig && icfg_q.raw_en) stat_q <= 1'b1;
         if (clr)                        lat_q  <= 1'b0;
         else if (trig && icfg_q.int_en) lat_q  <= 1'b1;
      end
   end

   always_comb begin
      rd_word = '0;
      case (rk)
         RK_CFG:   rd_word[CFG_OE_BIT] = oe_q;
         RK_IO:    begin
                      rd_word[IO_IN_BIT]  = lvl;
                      rd_word[IO_OUT_BIT] = drv_q;
                   end
         RK_ICFG:  rd_word[3:0] = icfg_q;
         RK_STAT:  rd_word[STAT_BIT] = stat_q;
         RK_ROUTE: rd_word[2:0] = route_q;
         default:  ;
      endcase
   end

   assign oe      = oe_q;
   assign drv     = drv_q;
   assign stat_o  = stat_q;
   assign lat_o   = lat_q;
   assign prev_o  = prev_q;
   assign icfg_o  = icfg_q;
   assign contrib = lat_q & icfg_q.int_en & (route_q == ROUTE_SUMMARY);
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 8,
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [BUS_DW-1:0]   bus_wdata,
   output logic [BUS_DW-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                irq_summary
);
   localparam int unsigned PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

   if (NUM_PINS < 1 || NUM_PINS > 256) begin : g_bad_pins
      $error("NUM_PINS must lie in 1..256");
   end
   if (ADDR_W < 13) begin : g_bad_addr
      $error("ADDR_W must be at least 13");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] lvl;
   logic [NUM_PINS-1:0] stat_vec, lat_vec, prev_vec, contrib_vec;
   logic [NUM_PINS-1:0] ien_vec, raw_vec, edge_vec;
   logic [BUS_DW-1:0]   rd_words [NUM_PINS];
   reg_kind_e           rk;
   logic [PIN_W-1:0]    psel;

   gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
   );

   gpio_addr_dec #(.ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_dec (
      .addr(bus_addr), .kind(rk), .pin(psel)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      icfg_t icfg_w;
      logic  wr_sel;

      assign wr_sel = bus_wr && (rk != RK_NONE) && (psel == PIN_W'(i));

      gpio_pin_unit u_unit (
         .clk(clk), .rst_n(rst_n), .wr_en(wr_sel), .rk(rk), .wdata(bus_wdata),
         .lvl(lvl[i]), .oe(pin_oe[i]), .drv(pin_out[i]), .rd_word(rd_words[i]),
         .stat_o(stat_vec[i]), .lat_o(lat_vec[i]), .prev_o(prev_vec[i]),
         .icfg_o(icfg_w), .contrib(contrib_vec[i])
      );

      assign ien_vec[i]  = icfg_w.int_en;
      assign raw_vec[i]  = icfg_w.raw_en;
      assign edge_vec[i] = icfg_w.edge_mode;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_summary <= 1'b0;
         bus_rdata   <= '0;
      end else begin
         irq_summary <= |contrib_vec;
         if (bus_rd) bus_rdata <= (rk == RK_NONE) ? '0 : rd_words[psel];
      end
   end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
   parameter int unsigned NUM_PINS = 8,
   parameter int unsigned ADDR_W   = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_wr,
   input logic                bus_rd,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [31:0]         bus_wdata,
   input logic [31:0]         bus_rdata,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic                irq_summary,
   input logic [NUM_PINS-1:0] lvl,
   input logic [NUM_PINS-1:0] prev_vec,
   input logic [NUM_PINS-1:0] stat_vec,
   input logic [NUM_PINS-1:0] lat_vec,
   input logic [NUM_PINS-1:0] contrib_vec,
   input logic [NUM_PINS-1:0] ien_vec,
   input logic [NUM_PINS-1:0] raw_vec,
   input logic [NUM_PINS-1:0] edge_vec
);
   logic unused_chk;
   assign unused_chk = ^bus_wdata;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(32'h1000 + 32'h10 * i);
      localparam logic [ADDR_W-1:0] A_IO  = ADDR_W'(32'h1004 + 32'h10 * i);
      localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(32'h100C + 32'h10 * i);

      // R2
      oe_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == A_CFG) |=> (pin_oe[i] == $past(bus_wdata[9])));
      // R2
      out_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == A_IO) |=> (pin_out[i] == $past(bus_wdata[1])));
      // R7
      status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == A_ST && bus_wdata[0]) |=> (!stat_vec[i] && !lat_vec[i]));
      // R6
      status_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(stat_vec[i]) |-> $past(raw_vec[i]));
      // R10
      latch_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(lat_vec[i]) |-> $past(ien_vec[i]));
      // R4
      edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(stat_vec[i]) && $past(edge_vec[i])) |-> ($past(lvl[i]) != $past(prev_vec[i])));
   end

   // R8
   summary_tracks_sources_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_summary == $past(|contrib_vec));
   // R9
   unmapped_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr < ADDR_W'(32'h400)) |=> (bus_rdata == 32'd0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe),
   .irq_summary(irq_summary), .lvl(lvl), .prev_vec(prev_vec), .stat_vec(stat_vec),
   .lat_vec(lat_vec), .contrib_vec(contrib_vec), .ien_vec(ien_vec), .raw_vec(raw_vec),
   .edge_vec(edge_vec)
);

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;
   localparam int NP = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [15:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe;
   logic          irq_summary;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic       m_oe  [NP];
   logic       m_out [NP];
   logic [3:0] m_icfg[NP];
   logic [2:0] m_rt  [NP];

   always #2.5 clk = ~clk;

   gpio_irq_bank #(.NUM_PINS(NP), .ADDR_W(16), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .irq_summary(irq_summary)
   );

   function automatic logic [15:0] a_cfg(int p);  return 16'h1000 + 16'(p * 16); endfunction
   function automatic logic [15:0] a_io(int p);   return 16'h1004 + 16'(p * 16); endfunction
   function automatic logic [15:0] a_icfg(int p); return 16'h1008 + 16'(p * 16); endfunction
   function automatic logic [15:0] a_st(int p);   return 16'h100C + 16'(p * 16); endfunction
   function automatic logic [15:0] a_rt(int p);   return 16'h0400 + 16'(p * 4);  endfunction

   // expected read of a model-tracked register; kind 0 cfg, 1 io, 2 icfg, 3 route
   function automatic logic [31:0] exp_rd(int kind, int p);
      case (kind)
         0:       return {22'd0, m_oe[p], 9'd0};
         1:       return {30'd0, m_out[p], pin_in[p]};
         2:       return {28'd0, m_icfg[p]};
         3:       return {29'd0, m_rt[p]};
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic [15:0] kind_addr(int kind, int p);
      case (kind)
         0:       return a_cfg(p);
         1:       return a_io(p);
         2:       return a_icfg(p);
         default: return a_rt(p);
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_pin(int p, logic v);
      @(negedge clk);
      pin_in[p] = v;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd1234));
      idle(4);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      check("R1 irq after reset", {31'd0, irq_summary}, 32'd0);
      check("R1 oe after reset", {24'd0, pin_oe}, 32'd0);
      check("R1 out after reset", {24'd0, pin_out}, 32'd0);
      for (int p = 0; p < NP; p++) begin
         rd(a_cfg(p), v);  check("R1 cfg reset", v, 32'd0);
         rd(a_io(p), v);   check("R1 io reset", v, 32'd0);
         rd(a_icfg(p), v); check("R1 icfg reset", v, 32'd0);
         rd(a_st(p), v);   check("R1 status reset", v, 32'd0);
         rd(a_rt(p), v);   check("R1 route reset", v, 32'd7);
      end

      // R2 output enable and drive
      wr(a_cfg(3), 32'h0000_0200);
      check("R2 oe set", {31'd0, pin_oe[3]}, 32'd1);
      wr(a_io(3), 32'h0000_0002);
      check("R2 out set", {31'd0, pin_out[3]}, 32'd1);
      rd(a_cfg(3), v); check("R2 cfg readback", v, 32'h200);
      wr(a_cfg(5), 32'hFFFF_FDFF);
      rd(a_cfg(5), v); check("R2 other cfg bits", v, 32'd0);
      check("R2 oe stays low", {31'd0, pin_oe[5]}, 32'd0);

      // R3 synchronised input, exact strobe latency
      set_pin(1, 1'b1);
      rd(a_io(1), v); check("R3 input one strobe early", v, 32'd0);
      rd(a_io(1), v); check("R3 input visible", v, 32'd1);
      set_pin(1, 1'b0);
      idle(4);
      wr(a_io(1), 32'h1);
      rd(a_io(1), v); check("R3 bit0 write ignored", v, 32'd0);

      // R4 rising edge, R8 latency, R7 clear
      wr(a_rt(2), 32'd4);
      wr(a_icfg(2), 32'hF);
      set_pin(2, 1'b1);
      idle(3);
      check("R8 summary not before 4th edge", {31'd0, irq_summary}, 32'd0);
      idle(1);
      check("R8 summary at 4th edge", {31'd0, irq_summary}, 32'd1);
      rd(a_st(2), v); check("R4 rising sets status", v, 32'd1);
      wr(a_st(2), 32'h0);
      rd(a_st(2), v); check("R7 write 0 keeps status", v, 32'd1);
      wr(a_st(2), 32'h1);
      check("R8 summary still high after clear edge", {31'd0, irq_summary}, 32'd1);
      idle(1);
      check("R8 summary drops", {31'd0, irq_summary}, 32'd0);
      rd(a_st(2), v); check("R7 status cleared", v, 32'd0);
      set_pin(2, 1'b0);
      idle(5);
      rd(a_st(2), v); check("R4 falling ignored in rising mode", v, 32'd0);
      check("R4 no summary on falling", {31'd0, irq_summary}, 32'd0);

      // R4 falling edge
      wr(a_icfg(2), 32'hD);
      set_pin(2, 1'b1);
      idle(5);
      rd(a_st(2), v); check("R4 rising ignored in falling mode", v, 32'd0);
      set_pin(2, 1'b0);
      idle(5);
      rd(a_st(2), v); check("R4 falling sets status", v, 32'd1);
      check("R4 falling raises summary", {31'd0, irq_summary}, 32'd1);
      wr(a_st(2), 32'h1);
      idle(2);
      check("R7 summary cleared", {31'd0, irq_summary}, 32'd0);
      wr(a_icfg(2), 32'h0);

      // R5 level mode re-capture
      wr(a_rt(4), 32'd4);
      wr(a_icfg(4), 32'hB);
      set_pin(4, 1'b1);
      idle(5);
      rd(a_st(4), v); check("R5 level sets status", v, 32'd1);
      check("R5 level raises summary", {31'd0, irq_summary}, 32'd1);
      wr(a_st(4), 32'h1);
      check("R5 summary high at clear edge", {31'd0, irq_summary}, 32'd1);
      idle(1);
      check("R5 one-cycle gap", {31'd0, irq_summary}, 32'd0);
      idle(1);
      check("R5 re-armed", {31'd0, irq_summary}, 32'd1);
      rd(a_st(4), v); check("R5 status re-captured", v, 32'd1);
      set_pin(4, 1'b0);
      idle(4);
      wr(a_st(4), 32'h1);
      idle(3);
      rd(a_st(4), v); check("R5 inactive level stays clear", v, 32'd0);
      check("R5 summary low", {31'd0, irq_summary}, 32'd0);
      wr(a_icfg(4), 32'h0);

      // R6 raw status disabled
      wr(a_rt(5), 32'd4);
      wr(a_icfg(5), 32'h7);
      set_pin(5, 1'b1);
      idle(5);
      check("R6 summary without status", {31'd0, irq_summary}, 32'd1);
      rd(a_st(5), v); check("R6 status not recorded", v, 32'd0);
      wr(a_st(5), 32'h1);
      idle(2);
      check("R6 clear drops summary", {31'd0, irq_summary}, 32'd0);

      // R8 routing codes and OR over pins
      wr(a_icfg(6), 32'hF);
      set_pin(6, 1'b1);
      idle(5);
      rd(a_st(6), v); check("R8 route 7 status", v, 32'd1);
      check("R8 route 7 blocks", {31'd0, irq_summary}, 32'd0);
      wr(a_rt(6), 32'd4);
      idle(2);
      check("R8 route 4 passes", {31'd0, irq_summary}, 32'd1);
      wr(a_rt(6), 32'd5);
      idle(2);
      check("R8 route 5 blocks", {31'd0, irq_summary}, 32'd0);
      wr(a_rt(6), 32'd4);
      wr(a_rt(7), 32'd4);
      wr(a_icfg(7), 32'hF);
      set_pin(7, 1'b1);
      idle(5);
      wr(a_st(6), 32'h1);
      idle(2);
      check("R8 other pin keeps summary", {31'd0, irq_summary}, 32'd1);
      wr(a_st(7), 32'h1);
      idle(2);
      check("R8 last source cleared", {31'd0, irq_summary}, 32'd0);

      // R10 no latch while disabled
      wr(a_rt(0), 32'd4);
      wr(a_icfg(0), 32'hE);
      set_pin(0, 1'b1);
      idle(5);
      rd(a_st(0), v); check("R10 status captured", v, 32'd1);
      check("R10 summary low while disabled", {31'd0, irq_summary}, 32'd0);
      wr(a_icfg(0), 32'hF);
      idle(3);
      check("R10 late enable no summary", {31'd0, irq_summary}, 32'd0);
      wr(a_st(0), 32'h1);
      set_pin(0, 1'b0);
      idle(4);
      set_pin(0, 1'b1);
      idle(5);
      check("R10 enabled edge raises summary", {31'd0, irq_summary}, 32'd1);
      wr(a_st(0), 32'h1);
      idle(2);

      // R9 unmapped addresses
      rd(16'h0000, v); check("R9 unmapped 0x0000", v, 32'd0);
      rd(16'h0420, v); check("R9 route index out of range", v, 32'd0);
      rd(16'h1080, v); check("R9 pin index out of range", v, 32'd0);
      rd(16'h1002, v); check("R9 misaligned", v, 32'd0);
      rd(16'h2000, v); check("R9 unmapped 0x2000", v, 32'd0);
      rd(16'h0800, v); check("R9 unmapped 0x0800", v, 32'd0);

      // random register traffic against the model (R2, R3, R9)
      for (int p = 0; p < NP; p++) begin
         wr(a_cfg(p), 32'h0); wr(a_io(p), 32'h0); wr(a_icfg(p), 32'h0); wr(a_rt(p), 32'h7);
         m_oe[p] = 1'b0; m_out[p] = 1'b0; m_icfg[p] = 4'h0; m_rt[p] = 3'd7;
      end
      @(negedge clk);
      pin_in = 8'($urandom);
      idle(4);
      for (int it = 0; it < 300; it++) begin
         int p, kind;
         logic [31:0] d;
         p = int'($urandom % NP);
         kind = int'($urandom % 5);
         d = $urandom;
         if (kind == 4) begin
            logic [15:0] ua;
            ua = 16'($urandom % 32'h400) & 16'hFFFC;
            wr(ua, d);
            rd(ua, v); check("R9 random unmapped", v, 32'd0);
         end else if ($urandom % 2 == 0) begin
            wr(kind_addr(kind, p), d);
            case (kind)
               0:       m_oe[p]   = d[9];
               1:       m_out[p]  = d[1];
               2:       m_icfg[p] = d[3:0];
               default: m_rt[p]   = d[2:0];
            endcase
         end else begin
            rd(kind_addr(kind, p), v);
            check("R2 R3 random readback", v, exp_rd(kind, p));
         end
      end
      for (int p = 0; p < NP; p++) begin
         check("R2 final oe", {31'd0, pin_oe[p]}, {31'd0, m_oe[p]});
         check("R2 final out", {31'd0, pin_out[p]}, {31'd0, m_out[p]});
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule